// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing logic of a byte-wide serial EEPROM. It attaches to a two-wire bus through a clock input and an open-drain data line. The data line is modelled as an input sample plus an output enable that can only pull the line low. The block recognises START and STOP conditions, answers only to its own device byte, and takes a two-byte word address. It then serves single-byte writes, page writes of 1 to 64 bytes, and random, current-address and sequential reads against an internal byte array.

Write data is gathered in a 64-byte page latch together with a per-byte valid mask. On the STOP that closes a write, the latched bytes are copied into the array during a self-timed programming interval. The length of that interval is a parameter, counted in system clocks. While the interval runs, the block does not answer to its own device byte, so a master can poll until the write has finished. A write-protect input, sampled on that STOP, cancels the copy. Two strap inputs set the device number, so four devices can share one bus.

The bus inputs are resynchronised to the system clock. The system clock must therefore run several times faster than the bus clock.

Top module: `eeprom_2w_slave`

## Requirements
- R1: The device byte is, MSB first, 1010, then 0, then strap_i[1], strap_i[0], then the read/write bit (1 = read). A matching byte is acknowledged by holding SDA low through the ninth clock. A non-matching byte gets no acknowledge, and every later byte gets none either until the next START.
- R2: SDA is sampled on the rising edge of SCL. sda_oe changes only while SCL is low, and the block never drives the line high.
- R3: After a write device byte, the word address is taken as a high byte and then a low byte, each acknowledged. High-byte bits at or above ADDR_W-8 are ignored.
- R4: A write that carries one data byte and ends with STOP stores that byte at the word address. It reads back after the programming interval.
- R5: In a page write, the low 6 address bits advance after each data byte and wrap within the 64-byte page. A later byte overwrites an earlier byte at the same offset. Only offsets that received a byte are changed.
- R6: A STOP that closes a write carrying data starts a programming interval of max(PROG_CYCLES, 64) clocks. During the interval the device byte is not acknowledged; after it ends, the device byte is acknowledged again.
- R7: If wp_i is high at that STOP, nothing is stored and no programming interval starts.
- R8: Random read: a write device byte and word address, then a repeated START and a read device byte, return the array byte at that address.
- R9: Current-address read: a read device byte with no word address returns the byte one past the last byte transferred.
- R10: In a read, each byte the master acknowledges is followed by the next byte. The full address increments and wraps from the last byte to 0. After a master NACK the block releases SDA and drives nothing until a START.
- R11: After reset, sda_oe is 0, no programming interval is running, and the device byte is acknowledged.
- R12: A write that ends with STOP after only the word address stores nothing and starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 2 | Device number straps |
| wp_i | input | 1 | Write protect, high blocks the store |

## Verification
A bad bit counter or a bad state shows up within one byte time. It appears either as a missing or misplaced acknowledge on the ninth clock, or as a read byte shifted by one bit. Faults in the page latch or the wrap logic stay hidden until the store completes. They then appear as wrong values on read-back at the wrapped offsets or at a neighbouring byte that should be unchanged. A bad programming timer shows at the ports as an acknowledge given too early, or never given again, to a device byte sent right after a write's STOP.

// File: rtl/eep2w_pkg.sv
`timescale 1ns/1ps
package eep2w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } bus_st_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         PAGE_W   = 6;
endpackage

// File: rtl/eep2w_bus_sync.sv
`timescale 1ns/1ps
module eep2w_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    typedef struct packed {
        logic scl1;
        logic scl2;
        logic scl_p;
        logic sda1;
        logic sda2;
        logic sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl1  = scl_i;
        d.scl2  = q.scl1;
        d.scl_p = q.scl2;
        d.sda1  = sda_i;
        d.sda2  = q.sda1;
        d.sda_p = q.sda2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s    = q.sda2;
    assign scl_rise = q.scl2 & ~q.scl_p;
    assign scl_fall = ~q.scl2 & q.scl_p;
    assign ev_start = q.scl2 & q.scl_p & q.sda_p & ~q.sda2;
    assign ev_stop  = q.scl2 & q.scl_p & ~q.sda_p & q.sda2;
endmodule

// File: rtl/eep2w_page_buf.sv
`timescale 1ns/1ps
module eep2w_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] raddr,
    output logic [7:0]        rdata,
    output logic              rvalid
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0]       slot_q [SLOTS];
    logic [SLOTS-1:0] valid_q, valid_d;

    always_comb begin
        valid_d = valid_q;
        if (clr) valid_d = '0;
        if (we)  valid_d[waddr] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (we) slot_q[waddr] <= wdata;
    end

    assign rdata  = slot_q[raddr];
    assign rvalid = valid_q[raddr];
endmodule

// File: rtl/eep2w_array.sv
`timescale 1ns/1ps
module eep2w_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/eeprom_2w_slave.sv
`timescale 1ns/1ps
module eeprom_2w_slave #(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);
    import eep2w_pkg::*;

    localparam int PG_W       = eep2w_pkg::PAGE_W;
    localparam int PAGE_BYTES = 1 << PG_W;
    localparam int BUSY_LEN   = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;
    localparam int TMR_W      = $clog2(BUSY_LEN + 1);
    localparam int BASE_W     = ADDR_W - PG_W;

    typedef struct packed {
        bus_st_e           st;
        logic [3:0]        cnt;
        logic              nine;
        logic [7:0]        sr;
        logic [7:0]        tx;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] addr;
        logic              rw;
        logic              mack;
        logic              oe;
        logic              got_data;
        logic              busy;
        logic [TMR_W-1:0]  tmr;
        logic              walking;
        logic [PG_W-1:0]   widx;
        logic [BASE_W-1:0] base;
    } ctl_t;

    ctl_t q, d;

    logic sda_s, ev_rise, ev_fall, ev_start, ev_stop;
    logic dev_match;
    logic pb_clr, pb_we, pb_rvalid, mem_we;
    logic [7:0] pb_rdata, mem_rdata;

    eep2w_bus_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (ev_rise),
        .scl_fall (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    eep2w_page_buf #(.PAGE_W(PG_W)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pb_clr),
        .we     (pb_we),
        .waddr  (q.addr[PG_W-1:0]),
        .wdata  (q.sr),
        .raddr  (q.widx),
        .rdata  (pb_rdata),
        .rvalid (pb_rvalid)
    );

    eep2w_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({q.base, q.widx}),
        .wdata (pb_rdata),
        .raddr (q.addr),
        .rdata (mem_rdata)
    );

    assign dev_match = (q.sr[7:4] == DEV_TYPE) && !q.sr[3] && (q.sr[2:1] == strap_i);

    always_comb begin
        d      = q;
        pb_clr = 1'b0;
        pb_we  = 1'b0;
        mem_we = 1'b0;

        // programming interval and page copy
        if (q.busy) begin
            d.tmr = q.tmr - 1'b1;
            if (q.tmr == TMR_W'(1)) d.busy = 1'b0;
        end
        if (q.walking) begin
            mem_we = pb_rvalid;
            d.widx = q.widx + 1'b1;
            if (&q.widx) d.walking = 1'b0;
        end

        // bus side
        if (ev_start) begin
            d.st   = ST_DEV;
            d.cnt  = '0;
            d.nine = 1'b0;
            d.oe   = 1'b0;
        end else if (ev_stop) begin
            d.st       = ST_IDLE;
            d.cnt      = '0;
            d.nine     = 1'b0;
            d.oe       = 1'b0;
            d.got_data = 1'b0;
            if (q.st == ST_WR && q.got_data && !wp_i) begin
                d.busy    = 1'b1;
                d.tmr     = TMR_W'(BUSY_LEN);
                d.walking = 1'b1;
                d.widx    = '0;
                d.base    = q.addr[ADDR_W-1:PG_W];
            end
        end else if (q.st != ST_IDLE) begin
            if (ev_rise) begin
                if (q.cnt < 4'd8) begin
                    d.sr  = {q.sr[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end else begin
                    d.nine = 1'b1;
                    d.mack = ~sda_s;
                end
            end
            if (ev_fall) begin
                if (q.cnt == 4'd8 && !q.nine) begin
                    // ninth clock begins: acknowledge slot
                    unique case (q.st)
                        ST_DEV: begin
                            if (dev_match && !q.busy) begin
                                d.oe = 1'b1;
                                d.rw = q.sr[0];
                                if (!q.sr[0]) begin
                                    pb_clr     = 1'b1;
                                    d.got_data = 1'b0;
                                end
                            end else begin
                                d.st = ST_IDLE;
                                d.oe = 1'b0;
                            end
                        end
                        ST_AHI: begin
                            d.oe  = 1'b1;
                            d.ahi = q.sr;
                        end
                        ST_ALO: begin
                            d.oe   = 1'b1;
                            d.addr = ADDR_W'({q.ahi, q.sr});
                        end
                        ST_WR: begin
                            d.oe                = 1'b1;
                            pb_we               = 1'b1;
                            d.addr[PG_W-1:0]    = q.addr[PG_W-1:0] + 1'b1;
                            d.got_data          = 1'b1;
                        end
                        ST_RD: d.oe = 1'b0;
                        default: d.oe = 1'b0;
                    endcase
                end else if (q.nine) begin
                    // acknowledge slot ends
                    d.cnt  = '0;
                    d.nine = 1'b0;
                    unique case (q.st)
                        ST_DEV: begin
                            if (q.rw) begin
                                d.st   = ST_RD;
                                d.tx   = mem_rdata;
                                d.oe   = ~mem_rdata[7];
                                d.addr = q.addr + 1'b1;
                            end else begin
                                d.st = ST_AHI;
                                d.oe = 1'b0;
                            end
                        end
                        ST_AHI: begin
                            d.st = ST_ALO;
                            d.oe = 1'b0;
                        end
                        ST_ALO: begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                        ST_WR: d.oe = 1'b0;
                        ST_RD: begin
                            if (q.mack) begin
                                d.tx   = mem_rdata;
                                d.oe   = ~mem_rdata[7];
                                d.addr = q.addr + 1'b1;
                            end else begin
                                d.st = ST_IDLE;
                                d.oe = 1'b0;
                            end
                        end
                        default: d.oe = 1'b0;
                    endcase
                end else if (q.st == ST_RD && q.cnt != 4'd0) begin
                    d.oe = ~q.tx[3'd7 - q.cnt[2:0]];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe = q.oe;

    // R2
    oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(ev_fall));

    // R6
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.st == ST_DEV && ev_fall && q.cnt == 4'd8 && !q.nine) |=> !q.oe);

    // R7
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !$past(wp_i));

    // R12
    data_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(q.got_data));

    // R4
    store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> q.busy);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);
endmodule

// File: tb/sim_eeprom_2w_slave.sv
`timescale 1ns/1ps
module sim_eeprom_2w_slave;
    localparam int H = 10;
    localparam logic [1:0] STRAP = 2'b01;
    localparam logic [7:0] DEVW = {4'b1010, 1'b0, STRAP, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, 1'b0, STRAP, 1'b1};

    // write address, data, read-back address
    localparam logic [39:0] VEC [8] = '{
        {16'h0005, 8'hA5, 16'h0005},
        {16'h0123, 8'h3C, 16'h0123},
        {16'h07FF, 8'h5A, 16'h07FF},
        {16'h0000, 8'hC3, 16'h0000},
        {16'h0001, 8'h96, 16'h0001},
        {16'h0400, 8'h0F, 16'h0400},
        {16'hF810, 8'h77, 16'h0010},
        {16'h02A0, 8'hE1, 16'h02A0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   ntests = 0;
    int   nfail = 0;
    int   r2_viol = 0;
    logic done = 1'b0;
    logic [7:0] wbuf [70];
    logic [7:0] rbuf [4];

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    eeprom_2w_slave #(.ADDR_W(11), .PROG_CYCLES(300)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .wp_i    (wp)
    );

    // R2: the output enable must not move while SCL stays high
    logic scl_p = 1'b1;
    logic oe_p = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && scl && scl_p && (sda_oe !== oe_p)) r2_viol++;
        scl_p = scl;
        oe_p  = sda_oe;
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bstart();
        hw(H/2); m_low = 1'b0; hw(H/2); scl = 1'b1; hw(H); m_low = 1'b1; hw(H); scl = 1'b0;
    endtask

    task automatic bstop();
        hw(H/2); m_low = 1'b1; hw(H/2); scl = 1'b1; hw(H); m_low = 1'b0; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            hw(H/2); m_low = ~b[i]; hw(H/2); scl = 1'b1; hw(H); scl = 1'b0;
        end
        hw(H/2); m_low = 1'b0; hw(H/2); scl = 1'b1; hw(H/2); ack = ~sda_line; hw(H/2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            hw(H/2); m_low = 1'b0; hw(H/2); scl = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); scl = 1'b0;
        end
        hw(H/2); m_low = mack; hw(H/2); scl = 1'b1; hw(H); scl = 1'b0;
    endtask

    task automatic write_mem(input logic [15:0] a, input int n, output logic all_ack);
        logic ack;
        all_ack = 1'b1;
        bstart();
        send_byte(DEVW, ack);    all_ack &= ack;
        send_byte(a[15:8], ack); all_ack &= ack;
        send_byte(a[7:0], ack);  all_ack &= ack;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack); all_ack &= ack;
        end
        bstop();
    endtask

    task automatic poll(output logic ack);
        bstart();
        send_byte(DEVW, ack);
        bstop();
    endtask

    task automatic wait_ready(output logic ack);
        ack = 1'b0;
        for (int k = 0; k < 40 && !ack; k++) poll(ack);
    endtask

    task automatic rd_rand(input logic [15:0] a, input int n);
        logic ack;
        bstart();
        send_byte(DEVW, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        bstart();
        send_byte(DEVR, ack);
        for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
        bstop();
    endtask

    task automatic check_at(input logic [15:0] a, input logic [7:0] exp, input string req);
        rd_rand(a, 1);
        chk(rbuf[0] == exp, req, rbuf[0], exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic seen;

        hw(10);
        rst_n = 1'b1;
        hw(5);

        // R11 reset state
        chk(sda_oe == 1'b0, "R11 oe", sda_oe, 0);
        poll(ack);
        chk(ack, "R11 ack after reset", ack, 1);

        // table walk: R4 byte write, R8 random read, R3 address masking
        for (int v = 0; v < 8; v++) begin
            wbuf[0] = VEC[v][23:16];
            write_mem(VEC[v][39:24], 1, ack);
            chk(ack, "R3 R4 write acks", ack, 1);
            wait_ready(ack);
            check_at(VEC[v][15:0], VEC[v][23:16], "R4 R8 readback");
        end

        // R6 programming interval
        wbuf[0] = 8'h44;
        write_mem(16'h0300, 1, ack);
        poll(ack);
        chk(!ack, "R6 nack while busy", ack, 0);
        wait_ready(ack);
        chk(ack, "R6 ack after interval", ack, 1);
        check_at(16'h0300, 8'h44, "R6 data stored");

        // R7 write protect
        wp = 1'b1;
        wbuf[0] = 8'h99;
        write_mem(16'h0005, 1, ack);
        poll(ack);
        chk(ack, "R7 no interval", ack, 1);
        wp = 1'b0;
        check_at(16'h0005, 8'hA5, "R7 unchanged");

        // R12 address-only write
        write_mem(16'h0123, 0, ack);
        poll(ack);
        chk(ack, "R12 no interval", ack, 1);
        check_at(16'h0123, 8'h3C, "R12 unchanged");

        // R5 page wrap with neighbour
        wbuf[0] = 8'h11; write_mem(16'h017F, 1, ack); wait_ready(ack);
        wbuf[0] = 8'h22; write_mem(16'h0150, 1, ack); wait_ready(ack);
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hB0 + 8'(k);
        write_mem(16'h017E, 4, ack);
        wait_ready(ack);
        check_at(16'h017E, 8'hB0, "R5 wrap first");
        check_at(16'h017F, 8'hB1, "R5 wrap last");
        check_at(16'h0140, 8'hB2, "R5 wrapped to start");
        check_at(16'h0141, 8'hB3, "R5 wrapped second");
        check_at(16'h0150, 8'h22, "R5 untouched offset");

        // R5 more than a page: later bytes overwrite earlier
        for (int k = 0; k < 66; k++) wbuf[k] = 8'(k + 1);
        write_mem(16'h0200, 66, ack);
        wait_ready(ack);
        check_at(16'h0200, 8'h41, "R5 overwrite slot0");
        check_at(16'h0201, 8'h42, "R5 overwrite slot1");
        check_at(16'h0202, 8'h03, "R5 slot2 kept");

        // R10 sequential read with rollover
        rd_rand(16'h07FF, 2);
        chk(rbuf[0] == 8'h5A, "R10 seq byte0", rbuf[0], 8'h5A);
        chk(rbuf[1] == 8'hC3, "R10 rollover to 0", rbuf[1], 8'hC3);

        // R9 current address, then R10 release after NACK
        bstart();
        send_byte(DEVR, ack);
        recv_byte(1'b0, b);
        chk(b == 8'h96, "R9 current address", b, 8'h96);
        seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            hw(H/2); seen |= sda_oe; hw(H/2); scl = 1'b1;
            hw(H/2); seen |= sda_oe; hw(H/2); scl = 1'b0;
        end
        chk(!seen, "R10 released after nack", seen, 0);
        bstop();

        // R1 address mismatch ignored until START
        bstart();
        send_byte({4'b1010, 1'b0, 2'b10, 1'b0}, ack);
        chk(!ack, "R1 strap mismatch", ack, 0);
        send_byte(DEVW, ack);
        chk(!ack, "R1 ignored until start", ack, 0);
        bstop();
        bstart();
        send_byte({4'b1011, 1'b0, STRAP, 1'b0}, ack);
        chk(!ack, "R1 type mismatch", ack, 0);
        bstop();
        poll(ack);
        chk(ack, "R1 match acked", ack, 1);

        chk(r2_viol == 0, "R2 oe stable while scl high", r2_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule